// File: doc/BRIEF.md
# Flip-Flop Joint-State Occupancy Profiler

This block observes a group of target flip-flops, taking the data input and the stored output of each one once per clock. Each observed pair is placed in one of four joint states. Over an observation window of programmable length, the block counts how many cycles each flip-flop spends in each joint state. Software can then form the occupancy fractions by dividing each count by the window length.

Each joint state has a different sensitivity to upsets, so the block also keeps a combined figure. This figure is the sum, over all monitored flip-flops, of each state count multiplied by a programmable 16-bit weight for that state. The weights stand for per-state sensitivity values that were measured elsewhere.

A start pulse captures the window length and the weights and clears every count. Counting then runs for exactly the programmed number of cycles. A one-cycle done pulse marks the end of the window. The results stay unchanged until the next start.

Top module: `ffstate_profiler`

## Requirements
- R1: The joint-state code of a flip-flop is {d,q}: code 0 means d=0,q=0; code 1 means d=0,q=1; code 2 means d=1,q=0; code 3 means d=1,q=1. The count for flip-flop i and code k sits at `cnt_o[(i*4+k)*CNT_W +: CNT_W]`, and the weight for code k sits at `wt_i[k*WT_W +: WT_W]`.
- R2: On a clock edge where `start_i` is high, the block clears all counts, the window counter and the weighted sum, and captures `win_len_i` and `wt_i`. The sample on that edge is not counted. A start while a window is running restarts the window. Changes to `win_len_i` or `wt_i` after the start have no effect on that window.
- R3: On each counting cycle, every monitored flip-flop adds one to exactly one of its four counts. The four counts of each flip-flop always add up to `win_cnt_o`.
- R4: Counting stops after exactly `win_len_i` samples. At that point `busy_o` falls and `win_cnt_o` equals the captured length.
- R5: `done_o` is high for exactly one cycle, on the cycle after the edge that takes the final sample. If the window length is 0, `done_o` rises on the cycle after the start and all counts stay zero. `busy_o` and `done_o` are never high together.
- R6: `wsum_o` equals the sum over all flip-flops i and all codes k of weight(k) × count(i,k). It never wraps, even with every weight at its maximum and the longest window.
- R7: While no window is running and `start_i` is low, changes on `d_i`, `q_i`, `wt_i` and `win_len_i` leave every output unchanged.
- R8: After reset, `busy_o`, `done_o`, `win_cnt_o`, all counts and `wsum_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or restart an observation window |
| win_len_i | input | CNT_W | Window length in cycles, captured at start |
| wt_i | input | 4*WT_W | Per-state weights, captured at start |
| d_i | input | N_FF | Sampled data inputs of the targets |
| q_i | input | N_FF | Sampled outputs of the targets |
| busy_o | output | 1 | Window in progress |
| done_o | output | 1 | One-cycle end-of-window pulse |
| win_cnt_o | output | CNT_W | Samples taken in the current window |
| cnt_o | output | N_FF*4*CNT_W | Per-flip-flop, per-state occupancy counts |
| wsum_o | output | CNT_W+WT_W+clog2(N_FF+1) | Weighted occupancy sum |

## Verification
The assertions check the following on every cycle:
- the four counts of each flip-flop add up to the window counter;
- the window counter never passes the captured length;
- done is a single-cycle pulse and never overlaps busy;
- the counts hold while idle;
- the weighted sum never decreases while counting, which would reveal a wrap.

Only the directed scenarios can show the rest:
- that each {d,q} pair lands in the right count slot;
- that the weighted sum has the exact expected value;
- that a restart or a late change to the weights or length is handled correctly;
- the boundary lengths of zero, one and the maximum.

// File: rtl/ffp_pkg.sv
package ffp_pkg;

   localparam int unsigned NUM_JSTATES = 4;

   typedef enum logic [1:0] {
      JS_D0_Q0 = 2'd0,
      JS_D0_Q1 = 2'd1,
      JS_D1_Q0 = 2'd2,
      JS_D1_Q1 = 2'd3
   } jstate_e;

   function automatic jstate_e classify(input logic d, input logic q);
      return jstate_e'({d, q});
   endfunction

endpackage

// File: rtl/ffp_window_ctrl.sv
module ffp_window_ctrl #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             sample_o,
   output logic [CNT_W-1:0] win_cnt_o
);

   logic [CNT_W-1:0] len_q;
   logic             last_sample;

   assign last_sample = (win_cnt_o == (len_q - CNT_W'(1)));
   assign sample_o    = busy_o && !start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q     <= '0;
         win_cnt_o <= '0;
         busy_o    <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            len_q     <= len_i;
            win_cnt_o <= '0;
            busy_o    <= (len_i != '0);
            done_o    <= (len_i == '0);
         end else if (busy_o) begin
            win_cnt_o <= win_cnt_o + CNT_W'(1);
            if (last_sample) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   // R4: window counter never runs past the captured length
   p_win_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      win_cnt_o <= len_q);

   // R5: done is a single-cycle pulse
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);

   // R5: busy and done never overlap
   p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));

endmodule

// File: rtl/ffp_state_counters.sv
module ffp_state_counters
   import ffp_pkg::*;
#(
   parameter int unsigned N_FF  = 4,
   parameter int unsigned CNT_W = 12
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clear_i,
   input  logic                             sample_i,
   input  logic [N_FF-1:0]                  d_i,
   input  logic [N_FF-1:0]                  q_i,
   input  logic [CNT_W-1:0]                 win_cnt_i,
   output logic [N_FF*NUM_JSTATES*CNT_W-1:0] cnt_o
);

   localparam int unsigned SUMCHK_W = CNT_W + 2;

   for (genvar i = 0; i < N_FF; i++) begin : g_ff
      jstate_e          st;
      logic [CNT_W-1:0] cnt [NUM_JSTATES];
      logic [SUMCHK_W-1:0] cnt_total;

      assign st = classify(d_i[i], q_i[i]);

      for (genvar k = 0; k < NUM_JSTATES; k++) begin : g_state
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt[k] <= '0;
            end else if (clear_i) begin
               cnt[k] <= '0;
            end else if (sample_i && (st == jstate_e'(k))) begin
               cnt[k] <= cnt[k] + CNT_W'(1);
            end
         end
         assign cnt_o[(i*NUM_JSTATES+k)*CNT_W +: CNT_W] = cnt[k];
      end

      always_comb begin
         cnt_total = '0;
         for (int k = 0; k < NUM_JSTATES; k++) begin
            cnt_total = cnt_total + SUMCHK_W'(cnt[k]);
         end
      end

      // R3: four counts of a flip-flop always add to the window count
      p_sum_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_total == SUMCHK_W'(win_cnt_i));
   end

   // R7: counts hold while neither sampling nor clearing
   p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_i && !clear_i) |=> $stable(cnt_o));

endmodule

// File: rtl/ffp_weight_accum.sv
module ffp_weight_accum
   import ffp_pkg::*;
#(
   parameter int unsigned N_FF  = 4,
   parameter int unsigned WT_W  = 16,
   parameter int unsigned SUM_W = 31
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear_i,
   input  logic                        sample_i,
   input  logic [NUM_JSTATES*WT_W-1:0] wt_i,
   input  logic [N_FF-1:0]             d_i,
   input  logic [N_FF-1:0]             q_i,
   output logic [SUM_W-1:0]            wsum_o
);

   localparam int unsigned INC_W = WT_W + $clog2(N_FF + 1);

   logic [WT_W-1:0]  wt_q [NUM_JSTATES];
   logic [WT_W-1:0]  sel  [N_FF];
   logic [INC_W-1:0] inc;

   for (genvar k = 0; k < NUM_JSTATES; k++) begin : g_wt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       wt_q[k] <= '0;
         else if (clear_i) wt_q[k] <= wt_i[k*WT_W +: WT_W];
      end
   end

   for (genvar i = 0; i < N_FF; i++) begin : g_sel
      assign sel[i] = wt_q[classify(d_i[i], q_i[i])];
   end

   always_comb begin
      inc = '0;
      for (int i = 0; i < N_FF; i++) begin
         inc = inc + INC_W'(sel[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wsum_o <= '0;
      else if (clear_i)  wsum_o <= '0;
      else if (sample_i) wsum_o <= wsum_o + SUM_W'(inc);
   end

   // R6: accumulator never wraps while counting
   p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_i |=> (wsum_o >= $past(wsum_o)));

endmodule

// File: rtl/ffstate_profiler.sv
module ffstate_profiler
   import ffp_pkg::*;
#(
   parameter int unsigned N_FF  = 4,
   parameter int unsigned CNT_W = 12,
   parameter int unsigned WT_W  = 16,
   localparam int unsigned SUM_W = CNT_W + WT_W + $clog2(N_FF + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [CNT_W-1:0]             win_len_i,
   input  logic [4*WT_W-1:0]            wt_i,
   input  logic [N_FF-1:0]              d_i,
   input  logic [N_FF-1:0]              q_i,
   output logic                         busy_o,
   output logic                         done_o,
   output logic [CNT_W-1:0]             win_cnt_o,
   output logic [N_FF*4*CNT_W-1:0]      cnt_o,
   output logic [SUM_W-1:0]             wsum_o
);

   if (N_FF < 1) begin : g_bad_nff
      $error("ffstate_profiler: N_FF must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cntw
      $error("ffstate_profiler: CNT_W must be at least 2");
   end
   if (WT_W < 1) begin : g_bad_wtw
      $error("ffstate_profiler: WT_W must be at least 1");
   end

   logic sample;

   ffp_window_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .len_i     (win_len_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .sample_o  (sample),
      .win_cnt_o (win_cnt_o)
   );

   ffp_state_counters #(.N_FF(N_FF), .CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (start_i),
      .sample_i  (sample),
      .d_i       (d_i),
      .q_i       (q_i),
      .win_cnt_i (win_cnt_o),
      .cnt_o     (cnt_o)
   );

   ffp_weight_accum #(.N_FF(N_FF), .WT_W(WT_W), .SUM_W(SUM_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (start_i),
      .sample_i (sample),
      .wt_i     (wt_i),
      .d_i      (d_i),
      .q_i      (q_i),
      .wsum_o   (wsum_o)
   );

   // R2: a start always empties the window on the next cycle
   p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (win_cnt_o == '0 && wsum_o == '0 && cnt_o == '0));

endmodule

// File: tb/ffstate_profiler_tb_top.sv
module ffstate_profiler_tb_top;

   localparam int N_FF  = 4;
   localparam int CNT_W = 12;
   localparam int WT_W  = 16;
   localparam int SUM_W = CNT_W + WT_W + $clog2(N_FF + 1);

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    start_i = 1'b0;
   logic [CNT_W-1:0]        win_len_i = '0;
   logic [4*WT_W-1:0]       wt_i = '0;
   logic [N_FF-1:0]         d_i = '0;
   logic [N_FF-1:0]         q_i = '0;
   logic                    busy_o, done_o;
   logic [CNT_W-1:0]        win_cnt_o;
   logic [N_FF*4*CNT_W-1:0] cnt_o;
   logic [SUM_W-1:0]        wsum_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int     exp_cnt [N_FF][4];
   longint exp_sum;
   int     exp_len;

   always #5 clk = ~clk;

   ffstate_profiler #(.N_FF(N_FF), .CNT_W(CNT_W), .WT_W(WT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .win_len_i(win_len_i),
      .wt_i(wt_i), .d_i(d_i), .q_i(q_i), .busy_o(busy_o), .done_o(done_o),
      .win_cnt_o(win_cnt_o), .cnt_o(cnt_o), .wsum_o(wsum_o)
   );

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int get_cnt(input int i, input int k);
      return int'(cnt_o[(i*4+k)*CNT_W +: CNT_W]);
   endfunction

   function automatic int pattern(input int mode, input int j, input int i);
      case (mode)
         0:       return i % 4;
         1:       return ((j * 7 + i * 3 + (j >> 2)) ^ ((j * 13) >> 1)) & 3;
         default: return (j + i) & 3;
      endcase
   endfunction

   task automatic check_all(input string req);
      for (int i = 0; i < N_FF; i++) begin
         int tot = 0;
         for (int k = 0; k < 4; k++) begin
            check(req, $sformatf("cnt ff%0d code%0d", i, k), get_cnt(i, k), exp_cnt[i][k]);
            tot += get_cnt(i, k);
         end
         check("R3", $sformatf("count total ff%0d", i), tot, exp_len);
      end
      check("R6", "wsum", longint'(wsum_o), exp_sum);
      check("R4", "win_cnt", win_cnt_o, exp_len);
   endtask

   // Starts a window at a negedge and drives len samples; returns at the
   // negedge after the final sampling edge.
   task automatic run_window(input int len, input int mode, input logic [4*WT_W-1:0] w);
      for (int i = 0; i < N_FF; i++) for (int k = 0; k < 4; k++) exp_cnt[i][k] = 0;
      exp_sum = 0;
      exp_len = len;
      win_len_i = CNT_W'(len);
      wt_i = w;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      // R2: late changes to length and weights must be ignored
      wt_i = ~w;
      win_len_i = CNT_W'(len + 5);
      for (int j = 0; j < len; j++) begin
         for (int i = 0; i < N_FF; i++) begin
            int c = pattern(mode, j, i);
            d_i[i] = c[1];
            q_i[i] = c[0];
            exp_cnt[i][c]++;
            exp_sum += longint'(w[c*WT_W +: WT_W]);
         end
         @(negedge clk);
      end
   endtask

   task automatic end_checks(input string req);
      check("R5", "done at window end", done_o, 1);
      check("R4", "busy at window end", busy_o, 0);
      check_all(req);
      @(negedge clk);
      check("R5", "done one cycle only", done_o, 0);
      check("R4", "win_cnt stopped", win_cnt_o, exp_len);
   endtask

   task automatic t_reset();
      check("R8", "busy after reset", busy_o, 0);
      check("R8", "done after reset", done_o, 0);
      check("R8", "win_cnt after reset", win_cnt_o, 0);
      check("R8", "cnt after reset", (cnt_o == '0), 1);
      check("R8", "wsum after reset", longint'(wsum_o), 0);
   endtask

   task automatic t_fixed_states();
      run_window(20, 0, {16'd1000, 16'd100, 16'd10, 16'd1});
      check("R3", "busy during last sample gone", busy_o, 0);
      // R1: ff i holds code i, so its whole window lands in slot i
      for (int i = 0; i < N_FF; i++)
         check("R1", $sformatf("ff%0d slot%0d", i, i), get_cnt(i, i), 20);
      end_checks("R1");
   endtask

   task automatic t_mixed();
      run_window(300, 1, {16'd7, 16'd300, 16'd65535, 16'd2});
      end_checks("R3");
   endtask

   task automatic t_len_one();
      run_window(1, 2, {16'd4, 16'd3, 16'd2, 16'd1});
      end_checks("R4");
   endtask

   task automatic t_len_zero();
      run_window(0, 2, {16'd9, 16'd9, 16'd9, 16'd9});
      check("R5", "done for zero length", done_o, 1);
      check("R5", "busy for zero length", busy_o, 0);
      check("R5", "counts zero for zero length", (cnt_o == '0), 1);
      check("R5", "wsum zero for zero length", longint'(wsum_o), 0);
      @(negedge clk);
      check("R5", "zero-length done one cycle", done_o, 0);
   endtask

   task automatic t_restart();
      win_len_i = 12'd50;
      wt_i = {4{16'd500}};
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int j = 0; j < 3; j++) begin
         d_i = '1; q_i = '1;
         @(negedge clk);
      end
      check("R2", "busy before restart", busy_o, 1);
      run_window(10, 2, {16'd11, 16'd22, 16'd33, 16'd44});
      end_checks("R2");
   endtask

   task automatic t_idle_ignore();
      logic [N_FF*4*CNT_W-1:0] c0;
      logic [SUM_W-1:0]        s0;
      run_window(8, 1, {16'd5, 16'd6, 16'd7, 16'd8});
      @(negedge clk);
      c0 = cnt_o;
      s0 = wsum_o;
      for (int j = 0; j < 10; j++) begin
         d_i = N_FF'(j * 5);
         q_i = ~N_FF'(j * 3);
         wt_i = {4{16'(j * 977)}};
         win_len_i = CNT_W'(j + 1);
         @(negedge clk);
      end
      check("R7", "counts hold while idle", (cnt_o == c0), 1);
      check("R7", "wsum holds while idle", longint'(wsum_o), longint'(s0));
      check("R7", "win_cnt holds while idle", win_cnt_o, 8);
      check("R7", "stays idle", busy_o, 0);
   endtask

   task automatic t_max_weights();
      run_window(4095, 2, {4{16'hFFFF}});
      end_checks("R6");
      check("R6", "max wsum no wrap", longint'(wsum_o), longint'(N_FF) * 4095 * 65535);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fixed_states();
      t_mixed();
      t_len_one();
      t_len_zero();
      t_restart();
      t_idle_ignore();
      t_max_weights();
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule